// File: doc/BRIEF.md
# Command-Mode Panel Write Engine (8080-style parallel bus)

This block pushes one complete frame of pixel words into a command-mode display panel over an 8080-style parallel write bus. The bus has an active-low chip select, an active-low write strobe and a data bus. A 20-bit timing word sets four phase lengths and an enable bit. Pixel words come from a valid/ready stream. Each accepted trigger starts one frame of `FRAME_WORDS` writes.

A frame can be started in two ways. Software can write the trigger-control port, or the panel can send a tearing-effect pulse, which only has an effect when a frame-update request is queued. A trigger that arrives while a frame is in flight is dropped, because repeated triggering can reset the panel. When a frame finishes, a sticky interrupt flag is raised if interrupts are enabled, and writing 1 clears it. While interrupts are enabled, the trigger lock holds until that interrupt fires. While they are disabled, the lock is released straight away.

Top module: `cmdpanel_wr_if`

## Requirements
- R1: Timing word fields are chip-select setup in bits 19:16, write setup in bits 15:12, write active in bits 11:8 and write hold in bits 7:4. Each phase lasts its field value in clock cycles, and a value of 0 gives one cycle. The write strobe stays low for exactly the write-active length.
- R2: A frame proceeds in this order. Chip select falls. The chip-select setup phase runs, then one fetch cycle, then write setup, and then the strobe falls. After the strobe rises, write hold runs, then one fetch cycle and write setup come before the next strobe. Chip select rises exactly the write-hold length after the last strobe rises. The strobe is never low while chip select is high. The fetch cycle assumes the stream has a word ready and stretches while `pix_valid_i` is low.
- R3: Each frame writes exactly `FRAME_WORDS` words, in stream order. Data does not change while the strobe is low. `pix_ready_o` is high only during a fetch cycle and only while chip select is low.
- R4: While timing-word bit 0 (enable) is 0, no trigger of either kind starts a frame.
- R5: A trigger-control write stores bit 0 as the trigger mode. The write starts a frame only when bits 1:0 equal 2'b11. A write with bit 0 clear starts nothing.
- R6: A trigger of either kind that arrives while a frame is in progress is ignored. It starts no further frame and consumes no queued request.
- R7: Each `upd_req_i` pulse adds one queued request, and the queue saturates at 2^`PEND_W`-1. A tearing-effect rising edge starts a frame only when the stored mode bit is 1 and the queue is non-empty. Such a start consumes exactly one request.
- R8: At frame completion, `irq_o` is set if `irq_en_i` is 1 and stays clear otherwise. A pulse on `irq_clr_i` clears it. If a set and a clear happen in the same cycle, the set wins.
- R9: With `irq_en_i` = 1, a trigger in the cycle in which chip select rises at frame end is ignored, because the lock is released only when the interrupt fires. With `irq_en_i` = 0, the same trigger is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_timing_i | input | 20 | Phase lengths and enable (bit 0) |
| trig_ctl_wr_i | input | 1 | Write strobe for the trigger-control value |
| trig_ctl_i | input | 2 | Bit 0: trigger mode, bit 1: software fire |
| te_i | input | 1 | Tearing-effect pulse from the panel (asynchronous) |
| upd_req_i | input | 1 | One-cycle frame-update request |
| irq_en_i | input | 1 | Frame-done interrupt enable |
| irq_clr_i | input | 1 | Write-1-to-clear for the interrupt flag |
| irq_o | output | 1 | Sticky frame-done interrupt flag |
| pix_valid_i | input | 1 | Pixel stream valid |
| pix_data_i | input | DATA_W | Pixel stream word |
| pix_ready_o | output | 1 | Pixel stream ready |
| lcd_cs_n_o | output | 1 | Panel chip select, active low |
| lcd_wr_n_o | output | 1 | Panel write strobe, active low |
| lcd_data_o | output | DATA_W | Panel data bus |

## Verification
A wrong phase counter shows up within one word as a strobe width or a setup gap that does not match the programmed value. A wrong word counter shows up when chip select rises, as a frame with too few or too many strobes. A bad queue count or a bad trigger lock is not visible until the next trigger. It then appears as a missing frame or an extra frame, so every trigger test counts falling edges of chip select over a quiet window after the stimulus. The interrupt flag is compared at the port one cycle after chip select rises.

// File: rtl/cmdpanel_pkg.sv
// Shared constants, phase encoding and helpers for the panel write engine.
// Assumes every phase field has the same width.
package cmdpanel_pkg;
    localparam int PH_W        = 4;
    localparam int CFG_W       = 20;
    localparam int CFG_EN_BIT  = 0;
    localparam int CFG_HLD_LSB = 4;
    localparam int CFG_ACT_LSB = 8;
    localparam int CFG_WSU_LSB = 12;
    localparam int CFG_CSU_LSB = 16;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_CSU,
        PH_FETCH,
        PH_WSU,
        PH_WACT,
        PH_WHLD
    } phase_e;

    // Counter load value for a phase: length-1, where a field of 0 means one cycle.
    function automatic logic [PH_W-1:0] load_val(input logic [PH_W-1:0] field);
        return (field == '0) ? '0 : field - 1'b1;
    endfunction
endpackage

// File: rtl/cmdpanel_te_edge.sv
// Synchronises the panel tearing-effect input and emits a one-cycle pulse
// on its rising edge. Assumes te_i is asynchronous to clk.
module cmdpanel_te_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic te_i,
    output logic pulse_o
);
    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    for (genvar i = 0; i < STAGES; i++) begin : g_sync
        // Shift the sampled level one stage down the synchroniser chain.
        always_ff @(posedge clk) begin
            if (!rst_n)      sync_q[i] <= 1'b0;
            else if (i == 0) sync_q[i] <= te_i;
            else             sync_q[i] <= sync_q[(i == 0) ? 0 : i-1];
        end
    end

    // Remember the last synchronised level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sync_q[STAGES-1];
    end

    assign pulse_o = sync_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/cmdpanel_trig_arb.sv
// Decides when a frame starts. Holds the trigger mode bit, the queue of
// frame-update requests, the trigger lock and the sticky interrupt flag.
// Assumes busy_i is high from the cycle after start_o until the frame ends.
module cmdpanel_trig_arb #(
    parameter int PEND_W = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       if_en_i,
    input  logic       tc_wr_i,
    input  logic [1:0] tc_val_i,
    input  logic       te_pulse_i,
    input  logic       upd_req_i,
    input  logic       irq_en_i,
    input  logic       irq_clr_i,
    input  logic       busy_i,
    input  logic       done_i,
    output logic       start_o,
    output logic       irq_o
);
    logic              mode_q;
    logic              lock_q;
    logic              irq_q;
    logic [PEND_W-1:0] pend_q;
    logic              sw_go, te_go, consume, inc;

    assign sw_go   = tc_wr_i && (tc_val_i == 2'b11);
    assign te_go   = te_pulse_i && mode_q && (pend_q != '0);
    assign start_o = if_en_i && !busy_i && !lock_q && (sw_go || te_go);
    assign consume = start_o && te_go;
    assign inc     = upd_req_i && !(&pend_q);
    assign irq_o   = irq_q;

    // Store the trigger mode on each trigger-control write.
    always_ff @(posedge clk) begin
        if (!rst_n)       mode_q <= 1'b0;
        else if (tc_wr_i) mode_q <= tc_val_i[0];
    end

    // Saturating count of queued update requests.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else begin
            case ({inc, consume})
                2'b10:   pend_q <= pend_q + 1'b1;
                2'b01:   pend_q <= pend_q - 1'b1;
                default: pend_q <= pend_q;
            endcase
        end
    end

    // Trigger lock: held until the interrupt fires, dropped at once without one.
    always_ff @(posedge clk) begin
        if (!rst_n)         lock_q <= 1'b0;
        else if (start_o)   lock_q <= 1'b1;
        else if (!irq_en_i) lock_q <= 1'b0;
        else if (done_i)    lock_q <= 1'b0;
    end

    // Sticky frame-done flag, write-1-to-clear, set has priority.
    always_ff @(posedge clk) begin
        if (!rst_n)                    irq_q <= 1'b0;
        else if (done_i && irq_en_i)   irq_q <= 1'b1;
        else if (irq_clr_i)            irq_q <= 1'b0;
    end
endmodule

// File: rtl/cmdpanel_wr_seq.sv
// Phase sequencer for one frame of bus writes. Chip select is held across
// the frame and every word runs fetch, write setup, write active and write
// hold. Assumes the phase lengths stay constant while a frame is in flight.
module cmdpanel_wr_seq
    import cmdpanel_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int FRAME_WORDS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [PH_W-1:0]   csu_i,
    input  logic [PH_W-1:0]   wsu_i,
    input  logic [PH_W-1:0]   wact_i,
    input  logic [PH_W-1:0]   whld_i,
    input  logic              pix_valid_i,
    input  logic [DATA_W-1:0] pix_data_i,
    output logic              pix_ready_o,
    output logic              cs_n_o,
    output logic              wr_n_o,
    output logic [DATA_W-1:0] data_o,
    output logic              busy_o,
    output logic              done_o
);
    localparam int WCNT_W = $clog2(FRAME_WORDS + 1);
    localparam logic [WCNT_W-1:0] LAST_WORD = WCNT_W'(FRAME_WORDS - 1);

    phase_e            st, nx;
    logic [PH_W-1:0]   cnt_q, cnt_nx;
    logic [WCNT_W-1:0] wcnt_q;
    logic              cs_n_q, wr_n_q, done_q;
    logic [DATA_W-1:0] data_q;
    logic              last_word;

    assign last_word   = (wcnt_q == LAST_WORD);
    assign pix_ready_o = (st == PH_FETCH);
    assign busy_o      = (st != PH_IDLE);
    assign cs_n_o      = cs_n_q;
    assign wr_n_o      = wr_n_q;
    assign data_o      = data_q;
    assign done_o      = done_q;

    // Next phase and phase-counter value.
    always_comb begin
        nx     = st;
        cnt_nx = cnt_q;
        case (st)
            PH_IDLE: if (start_i) begin
                nx     = PH_CSU;
                cnt_nx = load_val(csu_i);
            end
            PH_CSU: begin
                if (cnt_q == '0) nx = PH_FETCH;
                else             cnt_nx = cnt_q - 1'b1;
            end
            PH_FETCH: if (pix_valid_i) begin
                nx     = PH_WSU;
                cnt_nx = load_val(wsu_i);
            end
            PH_WSU: begin
                if (cnt_q == '0) begin
                    nx     = PH_WACT;
                    cnt_nx = load_val(wact_i);
                end else cnt_nx = cnt_q - 1'b1;
            end
            PH_WACT: begin
                if (cnt_q == '0) begin
                    nx     = PH_WHLD;
                    cnt_nx = load_val(whld_i);
                end else cnt_nx = cnt_q - 1'b1;
            end
            PH_WHLD: begin
                if (cnt_q == '0) nx = last_word ? PH_IDLE : PH_FETCH;
                else             cnt_nx = cnt_q - 1'b1;
            end
            default: nx = PH_IDLE;
        endcase
    end

    // Phase register plus registered bus controls and the done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= PH_IDLE;
            cnt_q  <= '0;
            cs_n_q <= 1'b1;
            wr_n_q <= 1'b1;
            done_q <= 1'b0;
        end else begin
            st     <= nx;
            cnt_q  <= cnt_nx;
            cs_n_q <= (nx == PH_IDLE);
            wr_n_q <= (nx != PH_WACT);
            done_q <= (st == PH_WHLD) && (nx == PH_IDLE);
        end
    end

    // Word counter within the frame.
    always_ff @(posedge clk) begin
        if (!rst_n)                                             wcnt_q <= '0;
        else if (st == PH_IDLE)                                 wcnt_q <= '0;
        else if (st == PH_WHLD && cnt_q == '0 && !last_word)    wcnt_q <= wcnt_q + 1'b1;
    end

    // Latch the stream word at the fetch handshake.
    always_ff @(posedge clk) begin
        if (!rst_n)                              data_q <= '0;
        else if (st == PH_FETCH && pix_valid_i)  data_q <= pix_data_i;
    end

    // R2
    strobe_in_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_n_q |-> !cs_n_q);

    // R3
    data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_n_q && $past(!wr_n_q)) |-> $stable(data_q));

    // R3
    ready_in_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pix_ready_o |-> !cs_n_q);
endmodule

// File: rtl/cmdpanel_wr_if.sv
// Top of the command-mode panel write engine. It decodes the timing word and
// ties together tearing-effect detection, trigger arbitration and the write
// sequencer. Assumes cfg_timing_i is static while a frame runs.
module cmdpanel_wr_if
    import cmdpanel_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int FRAME_WORDS = 8,
    parameter int PEND_W      = 2,
    parameter int TE_SYNC     = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CFG_W-1:0]  cfg_timing_i,
    input  logic              trig_ctl_wr_i,
    input  logic [1:0]        trig_ctl_i,
    input  logic              te_i,
    input  logic              upd_req_i,
    input  logic              irq_en_i,
    input  logic              irq_clr_i,
    output logic              irq_o,
    input  logic              pix_valid_i,
    input  logic [DATA_W-1:0] pix_data_i,
    output logic              pix_ready_o,
    output logic              lcd_cs_n_o,
    output logic              lcd_wr_n_o,
    output logic [DATA_W-1:0] lcd_data_o
);
    logic te_pulse_w, start_w, busy_w, done_w;
    logic unused_cfg;

    assign unused_cfg = ^cfg_timing_i[CFG_HLD_LSB-1:1];

    cmdpanel_te_edge #(.STAGES(TE_SYNC)) u_te (
        .clk     (clk),
        .rst_n   (rst_n),
        .te_i    (te_i),
        .pulse_o (te_pulse_w)
    );

    cmdpanel_trig_arb #(.PEND_W(PEND_W)) u_arb (
        .clk        (clk),
        .rst_n      (rst_n),
        .if_en_i    (cfg_timing_i[CFG_EN_BIT]),
        .tc_wr_i    (trig_ctl_wr_i),
        .tc_val_i   (trig_ctl_i),
        .te_pulse_i (te_pulse_w),
        .upd_req_i  (upd_req_i),
        .irq_en_i   (irq_en_i),
        .irq_clr_i  (irq_clr_i),
        .busy_i     (busy_w),
        .done_i     (done_w),
        .start_o    (start_w),
        .irq_o      (irq_o)
    );

    cmdpanel_wr_seq #(.DATA_W(DATA_W), .FRAME_WORDS(FRAME_WORDS)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_w),
        .csu_i       (cfg_timing_i[CFG_CSU_LSB +: PH_W]),
        .wsu_i       (cfg_timing_i[CFG_WSU_LSB +: PH_W]),
        .wact_i      (cfg_timing_i[CFG_ACT_LSB +: PH_W]),
        .whld_i      (cfg_timing_i[CFG_HLD_LSB +: PH_W]),
        .pix_valid_i (pix_valid_i),
        .pix_data_i  (pix_data_i),
        .pix_ready_o (pix_ready_o),
        .cs_n_o      (lcd_cs_n_o),
        .wr_n_o      (lcd_wr_n_o),
        .data_o      (lcd_data_o),
        .busy_o      (busy_w),
        .done_o      (done_w)
    );

    // R6
    start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_w |-> lcd_cs_n_o);

    // R2
    start_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_w |=> !lcd_cs_n_o);

    // R8
    irq_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_w && irq_en_i) |=> irq_o);
endmodule

// File: tb/cmdpanel_wr_if_tb.sv
`timescale 1ns/1ps
module cmdpanel_wr_if_tb;
    localparam int DW = 16;
    localparam int FW = 8;
    localparam int PW = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [19:0] cfg = '0;
    logic tc_wr = 1'b0;
    logic [1:0] tc_val = '0;
    logic te = 1'b0, upd = 1'b0, irq_en = 1'b0, irq_clr = 1'b0;
    logic pix_valid = 1'b0;
    logic [DW-1:0] pix_data = '0;
    logic irq, pix_ready, lcd_cs_n, lcd_wr_n;
    logic [DW-1:0] lcd_data;

    always #2 clk = ~clk;

    cmdpanel_wr_if #(.DATA_W(DW), .FRAME_WORDS(FW), .PEND_W(PW)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_timing_i(cfg),
        .trig_ctl_wr_i(tc_wr), .trig_ctl_i(tc_val), .te_i(te),
        .upd_req_i(upd), .irq_en_i(irq_en), .irq_clr_i(irq_clr), .irq_o(irq),
        .pix_valid_i(pix_valid), .pix_data_i(pix_data), .pix_ready_o(pix_ready),
        .lcd_cs_n_o(lcd_cs_n), .lcd_wr_n_o(lcd_wr_n), .lcd_data_o(lcd_data)
    );

    int n_chk = 0, n_bad = 0;
    int frames_started = 0;
    bit strict = 1'b1;
    logic [3:0] c_cs = 0, c_ws = 0, c_wa = 0, c_wh = 0;

    function automatic logic [DW-1:0] word_fn(input int unsigned i);
        return DW'((i * 32'd40503 + 32'd12345) ^ (i >> 3));
    endfunction

    function automatic int plen(input logic [3:0] v);
        return (v == 0) ? 1 : int'(v);
    endfunction

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_cfg(input logic [3:0] a, b, c, d, input logic en);
        c_cs = a; c_ws = b; c_wa = c; c_wh = d;
        cfg = {a, b, c, d, 3'b000, en};
    endtask

    task automatic sw_fire(input logic [1:0] v);
        tc_val = v; tc_wr = 1'b1;
        @(negedge clk);
        tc_wr = 1'b0; tc_val = '0;
    endtask

    task automatic te_fire();
        te = 1'b1; cyc(2); te = 1'b0; cyc(2);
    endtask

    task automatic upd_pulse();
        upd = 1'b1; cyc(1); upd = 1'b0;
    endtask

    task automatic wait_frame();
        while (lcd_cs_n)  @(negedge clk);
        while (!lcd_cs_n) @(negedge clk);
    endtask

    // Pixel stream source: word i of the stream is word_fn(i).
    initial begin : src
        int unsigned sidx = 0;
        bit hs = 0;
        forever begin
            @(negedge clk);
            if (hs) sidx++;
            pix_valid = strict ? 1'b1 : (($urandom % 4) != 0);
            pix_data  = word_fn(sidx);
            hs = pix_valid && pix_ready && rst_n;
        end
    end

    // Bus monitor: phase lengths, word order, data hold, words per frame.
    initial begin : mon
        bit m_pcs = 1, m_pwr = 1, first_w = 0;
        int hi_run = 0, lo_run = 0, words = 0, exp;
        int unsigned exp_idx = 0;
        logic [DW-1:0] lat = '0;
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (!lcd_cs_n && m_pcs) begin
                    frames_started++; first_w = 1; words = 0; hi_run = 0;
                end
                if (!lcd_cs_n && !lcd_wr_n && m_pwr) begin
                    if (strict) begin
                        exp = first_w ? plen(c_cs) + 1 + plen(c_ws) : plen(c_wh) + 1 + plen(c_ws);
                        chk(hi_run == exp, "R2 gap before strobe", hi_run, exp);
                    end
                    first_w = 0; lat = lcd_data; lo_run = 0;
                    chk(lat == word_fn(exp_idx), "R3 word order", lat, word_fn(exp_idx));
                end
                if (!lcd_wr_n) begin
                    lo_run++;
                    chk(lcd_data == lat, "R3 data hold", lcd_data, lat);
                end
                if (lcd_wr_n && !m_pwr) begin
                    chk(lo_run == plen(c_wa), "R1 strobe width", lo_run, plen(c_wa));
                    exp_idx++; words++; hi_run = 0;
                end
                if (lcd_cs_n && !m_pcs) begin
                    chk(hi_run == plen(c_wh), "R2 hold before release", hi_run, plen(c_wh));
                    chk(words == FW, "R3 words per frame", words, FW);
                end
                if (!lcd_cs_n && lcd_wr_n) hi_run++;
                m_pcs = lcd_cs_n; m_pwr = lcd_wr_n;
            end
        end
    end

    // Watchdog.
    initial begin : wd
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog R2 actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        int fs0;
        void'($urandom(32'd20240611));
        cyc(5);
        rst_n = 1'b1;
        cyc(1);
        // Reset state (R2, R3, R8)
        chk(lcd_cs_n == 1'b1, "R2 reset cs", lcd_cs_n, 1);
        chk(lcd_wr_n == 1'b1, "R2 reset wr", lcd_wr_n, 1);
        chk(pix_ready == 1'b0, "R3 reset ready", pix_ready, 0);
        chk(irq == 1'b0, "R8 reset irq", irq, 0);

        // R4: enable clear blocks triggers
        set_cfg(1, 1, 1, 1, 1'b0);
        fs0 = frames_started; sw_fire(2'b11); cyc(30);
        chk(frames_started == fs0, "R4 disabled sw trigger", frames_started - fs0, 0);

        // R1, R2: directed phase corners, interrupt on
        irq_en = 1'b1;
        set_cfg(0, 0, 0, 0, 1'b1); sw_fire(2'b11); wait_frame(); cyc(1);
        chk(irq == 1'b1, "R8 irq set", irq, 1);
        irq_clr = 1'b1; cyc(1); irq_clr = 1'b0; cyc(1);
        chk(irq == 1'b0, "R8 irq clear", irq, 0);
        set_cfg(15, 15, 15, 15, 1'b1); sw_fire(2'b11); wait_frame(); cyc(2);
        set_cfg(3, 1, 7, 2, 1'b1);     sw_fire(2'b11); wait_frame(); cyc(2);
        for (int k = 0; k < 3; k++) begin
            set_cfg(4'($urandom_range(0, 9)), 4'($urandom_range(0, 9)),
                    4'($urandom_range(0, 9)), 4'($urandom_range(0, 9)), 1'b1);
            sw_fire(2'b11); wait_frame(); cyc(2);
        end
        // R3: stalling stream
        strict = 1'b0;
        for (int k = 0; k < 3; k++) begin
            set_cfg(4'($urandom_range(0, 5)), 4'($urandom_range(0, 5)),
                    4'($urandom_range(0, 5)), 4'($urandom_range(0, 5)), 1'b1);
            sw_fire(2'b11); wait_frame(); cyc(2);
        end
        strict = 1'b1;
        irq_clr = 1'b1; cyc(1); irq_clr = 1'b0;

        // R5: write without mode bit does not fire
        set_cfg(2, 2, 2, 2, 1'b1);
        fs0 = frames_started; sw_fire(2'b10); cyc(30);
        chk(frames_started == fs0, "R5 fire without mode", frames_started - fs0, 0);

        // R6: software trigger during a frame is dropped
        fs0 = frames_started; sw_fire(2'b11);
        while (lcd_cs_n) @(negedge clk);
        cyc(3); sw_fire(2'b11);
        while (!lcd_cs_n) @(negedge clk);
        cyc(30);
        chk(frames_started == fs0 + 1, "R6 overlapping sw trigger", frames_started - fs0, 1);

        // R7: tearing-effect behaviour; mode bit cleared first
        set_cfg(0, 0, 0, 0, 1'b1);
        sw_fire(2'b00);
        upd_pulse();
        fs0 = frames_started; te_fire(); cyc(20);
        chk(frames_started == fs0, "R7 te with mode clear", frames_started - fs0, 0);
        sw_fire(2'b01); cyc(20);
        chk(frames_started == fs0, "R5 mode write alone", frames_started - fs0, 0);
        te_fire(); wait_frame(); cyc(2);
        chk(frames_started == fs0 + 1, "R7 queued request kept", frames_started - fs0, 1);
        fs0 = frames_started; te_fire(); cyc(30);
        chk(frames_started == fs0, "R7 te with empty queue", frames_started - fs0, 0);
        // Saturation: five requests, queue holds three
        for (int k = 0; k < 5; k++) upd_pulse();
        fs0 = frames_started;
        for (int k = 0; k < 4; k++) begin te_fire(); cyc(60); end
        chk(frames_started == fs0 + 3, "R7 queue saturation", frames_started - fs0, 3);
        // R6: tearing pulse during a frame neither starts nor consumes
        set_cfg(3, 3, 3, 3, 1'b1);
        upd_pulse(); upd_pulse();
        fs0 = frames_started; te_fire();
        while (lcd_cs_n) @(negedge clk);
        te_fire();
        while (!lcd_cs_n) @(negedge clk);
        cyc(20);
        chk(frames_started == fs0 + 1, "R6 overlapping te", frames_started - fs0, 1);
        te_fire(); wait_frame(); cyc(2);
        chk(frames_started == fs0 + 2, "R6 te request not consumed", frames_started - fs0, 2);
        // R4: enable clear blocks te as well
        upd_pulse();
        set_cfg(0, 0, 0, 0, 1'b0);
        fs0 = frames_started; te_fire(); cyc(20);
        chk(frames_started == fs0, "R4 disabled te", frames_started - fs0, 0);

        // R9: trigger in the frame-end cycle
        set_cfg(0, 0, 0, 0, 1'b1);
        irq_clr = 1'b1; cyc(1); irq_clr = 1'b0;
        irq_en = 1'b1;
        fs0 = frames_started; sw_fire(2'b11);
        while (lcd_cs_n)  @(negedge clk);
        while (!lcd_cs_n) @(negedge clk);
        tc_val = 2'b11; tc_wr = 1'b1; cyc(1); tc_wr = 1'b0;
        cyc(20);
        chk(frames_started == fs0 + 1, "R9 lock held until irq", frames_started - fs0, 1);
        irq_en = 1'b0;
        irq_clr = 1'b1; cyc(1); irq_clr = 1'b0;
        fs0 = frames_started; sw_fire(2'b11);
        while (lcd_cs_n)  @(negedge clk);
        while (!lcd_cs_n) @(negedge clk);
        tc_val = 2'b11; tc_wr = 1'b1; cyc(1); tc_wr = 1'b0;
        wait_frame(); cyc(2);
        chk(frames_started == fs0 + 2, "R9 no lock without irq", frames_started - fs0, 2);
        chk(irq == 1'b0, "R8 irq stays clear when disabled", irq, 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule